// File: doc/BRIEF.md
# Storage Controller Register Bank

This block is the 32-bit memory-mapped register window of a host-driven storage controller. Software reaches it over a simple single-cycle read/write bus. It holds the interrupt mask, the controller configuration word, the controller status word, the admin queue attributes, and the two 64-bit base addresses of the admin submission and completion queues. The queue engine itself is not part of the block. That engine supplies two flags saying whether admin queues already exist, and it receives the `ctrl_clear` pulse whenever the controller must drop its queue state.

A write to the configuration word drives a three-state enable machine. When the enable bit rises, an ordered list of start-up checks runs in the same cycle. The result moves the machine to EN_READY or to EN_FATAL, and the code of the first failed check is latched on `start_fault`. Shutdown requests are handled alongside and set or clear a shutdown-complete indication.

Accesses with no defined meaning do not stall or corrupt the bank. They produce a one-cycle `ua_strobe` together with a reason code on `ua_code`.

Enable machine states and transitions:
- EN_OFF to EN_READY on an enable rise with all checks passing.
- EN_OFF to EN_FATAL on an enable rise with a failing check.
- EN_READY to EN_OFF on an enable fall.
- EN_FATAL to EN_READY or EN_FATAL on a new enable rise, depending on the checks.
- EN_FATAL stays in EN_FATAL on an enable fall.

Top module: `sc_regbank`

## Requirements
- R1: A write to offset 0x0C ORs the data into the 32-bit interrupt mask, and a write to offset 0x10 clears the written bits. A read of either offset returns the resulting mask.
- R2: While `msix_on` is high, a mask write at 0x0C or 0x10 still takes effect and also raises `ua_strobe` with code 3.
- R3: In a write to the configuration word at 0x14, the enable bit is bit 0. A write that raises it from 0 stores the word and runs the start checks. On a pass `ctrl_status` bit 0 (ready) is set. On a failure `ctrl_status` bit 1 (fatal) is set. Either way `start_fault` shows the first failing check (0 when all pass).
- R4: The start checks are tried in this order and report these codes: admin completion queue exists (1); admin submission queue exists (2); submission base zero (3); completion base zero (4); submission base not aligned to the page (5); completion base not aligned (6); page field in bits 10:7 below `cap_pg_min` (7) or above `cap_pg_max` (8); completion entry field in bits 23:20 below its minimum (9) or above its maximum (10); submission entry field in bits 19:16 below its minimum (11) or above its maximum (12); queue-attribute bits 11:0 zero (13); queue-attribute bits 27:16 zero (14). The page size is 2 to the power (page field + 12).
- R5: A configuration write that drops the enable bit from 1 stores the word, pulses `ctrl_clear` for one cycle and clears ready. A fatal indication is kept.
- R6: The shutdown field is bits 15:14. Making it nonzero from zero pulses `ctrl_clear` and sets `ctrl_status` bits 3:2 to 2'b10. Returning it to zero clears those bits without a clear pulse.
- R7: A write to 0x28 or 0x30 replaces the whole 64-bit submission or completion base with the zero-extended data. A write to 0x2C or 0x34 ORs the data into bits 63:32. Each half reads back at its own offset.
- R8: Writes to the status word (0x1C) and to the buffer-region words (0x38, 0x3C) change no state. A status write with bit 4 set flags code 4. A status write with any other nonzero value flags code 5. A buffer-region write flags code 7.
- R9: Writing 0x4E564D65 to 0x20 flags code 6. Any other value written there has no effect and no flag.
- R10: A read at an offset of 0x40 or above returns zero and flags code 9. A write to an offset with no register (including 0x00 and 0x40 and above) flags code 8.
- R11: An access whose address bits 1:0 are nonzero flags code 1, changes nothing and reads as zero. A write narrower than 4 bytes flags code 2 and still takes effect.
- R12: After reset the mask, configuration, attributes and bases are zero, `ctrl_status` and `start_fault` are zero, and no strobe or pulse is active.
- R13: A configuration write that keeps the enable bit at 1 and does not move the shutdown field between zero and nonzero is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_valid | input | 1 | Access request this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address inside the window |
| bus_bytes | input | 3 | Access width in bytes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after the read |
| msix_on | input | 1 | Message-signalled interrupts enabled |
| adm_sq_live | input | 1 | Admin submission queue already exists |
| adm_cq_live | input | 1 | Admin completion queue already exists |
| cap_pg_min | input | 4 | Smallest allowed page field |
| cap_pg_max | input | 4 | Largest allowed page field |
| cap_cqe_min | input | 4 | Smallest allowed completion entry field |
| cap_cqe_max | input | 4 | Largest allowed completion entry field |
| cap_sqe_min | input | 4 | Smallest allowed submission entry field |
| cap_sqe_max | input | 4 | Largest allowed submission entry field |
| ctrl_clear | output | 1 | One-cycle request to drop controller queue state |
| ctrl_status | output | 4 | Bit 0 ready, bit 1 fatal, bits 3:2 shutdown state |
| start_fault | output | 4 | Code of the first failed start check |
| ua_strobe | output | 1 | One-cycle undefined-access flag |
| ua_code | output | 4 | Reason for the flag |

## Verification
The hardest situation to reach is a start-check failure deep in the ordered list. Each later check can only be seen once every earlier check passes. The stimulus therefore starts from a configuration that fails the first check and repairs one cause at a time: the queue-existence flags, then the zero and misaligned bases, the page and entry-size limits, and finally the queue sizes. After each repair it re-arms the enable bit with a disabling write, which also shows that a fatal indication survives an enable fall. The code on `start_fault` must step through 1 to 14 in order and then read 0 on the final pass.

// File: rtl/sc_pkg.sv
package sc_pkg;

    localparam int DATA_W  = 32;
    localparam int BASE_W  = 2 * DATA_W;
    localparam int FLD_W   = 4;
    localparam int QSZ_W   = 12;
    localparam int OFS_W   = 6;
    localparam int PG_BIAS = 12;

    // register offsets inside the window
    localparam logic [OFS_W-1:0] OFS_MSET  = 6'h0C;
    localparam logic [OFS_W-1:0] OFS_MCLR  = 6'h10;
    localparam logic [OFS_W-1:0] OFS_CFG   = 6'h14;
    localparam logic [OFS_W-1:0] OFS_STAT  = 6'h1C;
    localparam logic [OFS_W-1:0] OFS_SSR   = 6'h20;
    localparam logic [OFS_W-1:0] OFS_QATTR = 6'h24;
    localparam logic [OFS_W-1:0] OFS_SQLO  = 6'h28;
    localparam logic [OFS_W-1:0] OFS_SQHI  = 6'h2C;
    localparam logic [OFS_W-1:0] OFS_CQLO  = 6'h30;
    localparam logic [OFS_W-1:0] OFS_CQHI  = 6'h34;
    localparam logic [OFS_W-1:0] OFS_BLOC  = 6'h38;
    localparam logic [OFS_W-1:0] OFS_BSIZE = 6'h3C;

    // configuration word field positions
    localparam int CF_EN    = 0;
    localparam int CF_PG    = 7;
    localparam int CF_SHN   = 14;
    localparam int CF_SQE   = 16;
    localparam int CF_CQE   = 20;
    localparam int QA_CQ    = 16;

    localparam logic [DATA_W-1:0] SSR_KEY = 32'h4E56_4D65;

    typedef enum logic [1:0] {
        EN_OFF   = 2'd0,
        EN_READY = 2'd1,
        EN_FATAL = 2'd2
    } en_state_t;

    typedef enum logic [3:0] {
        UA_NONE      = 4'd0,
        UA_MISALIGN  = 4'd1,
        UA_NARROW    = 4'd2,
        UA_MASK_MSI  = 4'd3,
        UA_STAT_W1C  = 4'd4,
        UA_STAT_RO   = 4'd5,
        UA_SSR_KEY   = 4'd6,
        UA_BUF_RO    = 4'd7,
        UA_BAD_WRITE = 4'd8,
        UA_BAD_READ  = 4'd9
    } ua_code_t;

    typedef enum logic [3:0] {
        SF_PASS     = 4'd0,
        SF_CQ_LIVE  = 4'd1,
        SF_SQ_LIVE  = 4'd2,
        SF_SQ_NULL  = 4'd3,
        SF_CQ_NULL  = 4'd4,
        SF_SQ_ALIGN = 4'd5,
        SF_CQ_ALIGN = 4'd6,
        SF_PG_SMALL = 4'd7,
        SF_PG_LARGE = 4'd8,
        SF_CQE_LOW  = 4'd9,
        SF_CQE_HIGH = 4'd10,
        SF_SQE_LOW  = 4'd11,
        SF_SQE_HIGH = 4'd12,
        SF_SQ_EMPTY = 4'd13,
        SF_CQ_EMPTY = 4'd14
    } start_fault_t;

endpackage

// File: rtl/sc_start_check.sv
// Ordered start-up validity check, evaluated in the cycle of the enable write.
module sc_start_check
    import sc_pkg::*;
(
    input  logic              cq_live,
    input  logic              sq_live,
    input  logic [BASE_W-1:0] sq_base,
    input  logic [BASE_W-1:0] cq_base,
    input  logic [FLD_W-1:0]  pg_fld,
    input  logic [FLD_W-1:0]  cqe_fld,
    input  logic [FLD_W-1:0]  sqe_fld,
    input  logic [QSZ_W-1:0]  sq_size,
    input  logic [QSZ_W-1:0]  cq_size,
    input  logic [FLD_W-1:0]  pg_min,
    input  logic [FLD_W-1:0]  pg_max,
    input  logic [FLD_W-1:0]  cqe_min,
    input  logic [FLD_W-1:0]  cqe_max,
    input  logic [FLD_W-1:0]  sqe_min,
    input  logic [FLD_W-1:0]  sqe_max,
    output start_fault_t      fault
);
    logic [5:0]        pg_shift;
    logic [BASE_W-1:0] pg_mask;

    assign pg_shift = 6'(pg_fld) + 6'(PG_BIAS);
    assign pg_mask  = (BASE_W'(1) << pg_shift) - BASE_W'(1);

    // first failing condition wins; order is part of the behaviour
    always_comb begin
        if (cq_live)                          fault = SF_CQ_LIVE;
        else if (sq_live)                     fault = SF_SQ_LIVE;
        else if (sq_base == '0)               fault = SF_SQ_NULL;
        else if (cq_base == '0)               fault = SF_CQ_NULL;
        else if ((sq_base & pg_mask) != '0)   fault = SF_SQ_ALIGN;
        else if ((cq_base & pg_mask) != '0)   fault = SF_CQ_ALIGN;
        else if (pg_fld < pg_min)             fault = SF_PG_SMALL;
        else if (pg_fld > pg_max)             fault = SF_PG_LARGE;
        else if (cqe_fld < cqe_min)           fault = SF_CQE_LOW;
        else if (cqe_fld > cqe_max)           fault = SF_CQE_HIGH;
        else if (sqe_fld < sqe_min)           fault = SF_SQE_LOW;
        else if (sqe_fld > sqe_max)           fault = SF_SQE_HIGH;
        else if (sq_size == '0)               fault = SF_SQ_EMPTY;
        else if (cq_size == '0)               fault = SF_CQ_EMPTY;
        else                                  fault = SF_PASS;
    end
endmodule

// File: rtl/sc_access_check.sv
// Classifies each bus access and yields the undefined-access reason.
module sc_access_check
    import sc_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic              valid,
    input  logic              write,
    input  logic [ADDR_W-1:0] addr,
    input  logic [2:0]        bytes,
    input  logic [DATA_W-1:0] wdata,
    input  logic              msix_on,
    output logic              aligned,
    output logic              in_win,
    output ua_code_t          code
);
    localparam int WORD_BYTES = DATA_W / 8;

    logic [OFS_W-1:0] ofs;

    assign aligned = (addr[1:0] == 2'b00);
    assign in_win  = (addr[ADDR_W-1:OFS_W] == '0);
    assign ofs     = addr[OFS_W-1:0];

    always_comb begin
        code = UA_NONE;
        if (!valid) begin
            code = UA_NONE;
        end else if (!aligned) begin
            code = UA_MISALIGN;
        end else if (bytes < 3'(WORD_BYTES)) begin
            code = UA_NARROW;
        end else if (!write) begin
            code = in_win ? UA_NONE : UA_BAD_READ;
        end else if (!in_win) begin
            code = UA_BAD_WRITE;
        end else begin
            unique case (ofs)
                OFS_MSET, OFS_MCLR: code = msix_on ? UA_MASK_MSI : UA_NONE;
                OFS_CFG, OFS_QATTR, OFS_SQLO, OFS_SQHI,
                OFS_CQLO, OFS_CQHI: code = UA_NONE;
                OFS_STAT: begin
                    if (wdata[4])          code = UA_STAT_W1C;
                    else if (wdata != '0)  code = UA_STAT_RO;
                    else                   code = UA_NONE;
                end
                OFS_SSR:            code = (wdata == SSR_KEY) ? UA_SSR_KEY : UA_NONE;
                OFS_BLOC, OFS_BSIZE: code = UA_BUF_RO;
                default:            code = UA_BAD_WRITE;
            endcase
        end
    end
endmodule

// File: rtl/sc_enable_fsm.sv
// Enable state machine with the shutdown indication and the clear pulse.
module sc_enable_fsm
    import sc_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      en_rise,
    input  logic      en_fall,
    input  logic      shn_rise,
    input  logic      shn_fall,
    input  logic      pass,
    output en_state_t state,
    output logic      shdn_done,
    output logic      clr_pulse
);
    en_state_t state_nx;

    always_comb begin
        state_nx = state;
        unique case (state)
            EN_OFF:   if (en_rise) state_nx = pass ? EN_READY : EN_FATAL;
            EN_READY: if (en_fall) state_nx = EN_OFF;
            EN_FATAL: if (en_rise) state_nx = pass ? EN_READY : EN_FATAL;
            default:  state_nx = EN_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= EN_OFF;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shdn_done <= 1'b0;
            clr_pulse <= 1'b0;
        end else begin
            clr_pulse <= en_fall | shn_rise;
            if (shn_rise)      shdn_done <= 1'b1;
            else if (shn_fall) shdn_done <= 1'b0;
            else if (en_rise)  shdn_done <= 1'b0;
        end
    end
endmodule

// File: rtl/sc_regbank.sv
module sc_regbank
    import sc_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [2:0]        bus_bytes,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              msix_on,
    input  logic              adm_sq_live,
    input  logic              adm_cq_live,
    input  logic [3:0]        cap_pg_min,
    input  logic [3:0]        cap_pg_max,
    input  logic [3:0]        cap_cqe_min,
    input  logic [3:0]        cap_cqe_max,
    input  logic [3:0]        cap_sqe_min,
    input  logic [3:0]        cap_sqe_max,
    output logic              ctrl_clear,
    output logic [3:0]        ctrl_status,
    output logic [3:0]        start_fault,
    output logic              ua_strobe,
    output logic [3:0]        ua_code
);
    logic [DATA_W-1:0] irq_mask, cfg, qattr;
    logic [BASE_W-1:0] sq_base, cq_base;
    logic              aligned, in_win, wr_ok, cfg_wr;
    logic [OFS_W-1:0]  ofs;
    ua_code_t          acc_code;
    start_fault_t      fault;
    en_state_t         state;
    logic              shdn_done;
    logic              en_rise, en_fall, shn_rise, shn_fall, idle_wr, cfg_store;
    logic [1:0]        shn_old, shn_new;
    logic [DATA_W-1:0] rd_mux;

    assign ofs    = bus_addr[OFS_W-1:0];
    assign wr_ok  = bus_valid && bus_write && aligned && in_win;
    assign cfg_wr = wr_ok && (ofs == OFS_CFG);

    assign shn_old  = cfg[CF_SHN +: 2];
    assign shn_new  = bus_wdata[CF_SHN +: 2];
    assign en_rise  = cfg_wr &&  bus_wdata[CF_EN] && !cfg[CF_EN];
    assign en_fall  = cfg_wr && !bus_wdata[CF_EN] &&  cfg[CF_EN];
    assign shn_rise = cfg_wr && (shn_new != 2'b00) && (shn_old == 2'b00);
    assign shn_fall = cfg_wr && (shn_new == 2'b00) && (shn_old != 2'b00);
    assign idle_wr  = cfg_wr && !bus_wdata[CF_EN] && !cfg[CF_EN]
                      && (shn_new == 2'b00) && (shn_old == 2'b00);
    assign cfg_store = en_rise | en_fall | shn_rise | shn_fall | idle_wr;

    sc_access_check #(.ADDR_W(ADDR_W)) u_acc (
        .valid   (bus_valid),
        .write   (bus_write),
        .addr    (bus_addr),
        .bytes   (bus_bytes),
        .wdata   (bus_wdata),
        .msix_on (msix_on),
        .aligned (aligned),
        .in_win  (in_win),
        .code    (acc_code)
    );

    // checks use the configuration being written and the stored bases
    sc_start_check u_chk_start (
        .cq_live (adm_cq_live),
        .sq_live (adm_sq_live),
        .sq_base (sq_base),
        .cq_base (cq_base),
        .pg_fld  (bus_wdata[CF_PG  +: FLD_W]),
        .cqe_fld (bus_wdata[CF_CQE +: FLD_W]),
        .sqe_fld (bus_wdata[CF_SQE +: FLD_W]),
        .sq_size (qattr[QSZ_W-1:0]),
        .cq_size (qattr[QA_CQ +: QSZ_W]),
        .pg_min  (cap_pg_min),
        .pg_max  (cap_pg_max),
        .cqe_min (cap_cqe_min),
        .cqe_max (cap_cqe_max),
        .sqe_min (cap_sqe_min),
        .sqe_max (cap_sqe_max),
        .fault   (fault)
    );

    sc_enable_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .en_rise   (en_rise),
        .en_fall   (en_fall),
        .shn_rise  (shn_rise),
        .shn_fall  (shn_fall),
        .pass      (fault == SF_PASS),
        .state     (state),
        .shdn_done (shdn_done),
        .clr_pulse (ctrl_clear)
    );

    assign ctrl_status = {shdn_done, 1'b0, state == EN_FATAL, state == EN_READY};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_mask <= '0;
            cfg      <= '0;
            qattr    <= '0;
            sq_base  <= '0;
            cq_base  <= '0;
        end else if (wr_ok) begin
            unique case (ofs)
                OFS_MSET:  irq_mask <= irq_mask | bus_wdata;
                OFS_MCLR:  irq_mask <= irq_mask & ~bus_wdata;
                OFS_CFG:   if (cfg_store) cfg <= bus_wdata;
                OFS_QATTR: qattr <= bus_wdata;
                OFS_SQLO:  sq_base <= {{DATA_W{1'b0}}, bus_wdata};
                OFS_SQHI:  sq_base <= sq_base | {bus_wdata, {DATA_W{1'b0}}};
                OFS_CQLO:  cq_base <= {{DATA_W{1'b0}}, bus_wdata};
                OFS_CQHI:  cq_base <= cq_base | {bus_wdata, {DATA_W{1'b0}}};
                default:   ;
            endcase
        end
    end

    always_comb begin
        unique case (ofs)
            OFS_MSET, OFS_MCLR: rd_mux = irq_mask;
            OFS_CFG:            rd_mux = cfg;
            OFS_STAT:           rd_mux = {{(DATA_W-4){1'b0}}, ctrl_status};
            OFS_QATTR:          rd_mux = qattr;
            OFS_SQLO:           rd_mux = sq_base[DATA_W-1:0];
            OFS_SQHI:           rd_mux = sq_base[BASE_W-1:DATA_W];
            OFS_CQLO:           rd_mux = cq_base[DATA_W-1:0];
            OFS_CQHI:           rd_mux = cq_base[BASE_W-1:DATA_W];
            default:            rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bus_rdata   <= '0;
            start_fault <= '0;
            ua_strobe   <= 1'b0;
            ua_code     <= '0;
        end else begin
            if (bus_valid && !bus_write)
                bus_rdata <= (aligned && in_win) ? rd_mux : '0;
            if (en_rise)
                start_fault <= fault;
            ua_strobe <= (acc_code != UA_NONE);
            ua_code   <= acc_code;
        end
    end
endmodule

// File: rtl/sc_regbank_chk.sv
module sc_regbank_chk #(
    parameter int ADDR_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_valid,
    input logic              bus_write,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [31:0]       bus_wdata,
    input logic              ctrl_clear,
    input logic [3:0]        ctrl_status,
    input logic              ua_strobe,
    input logic [3:0]        ua_code
);
    // R3: ready and fatal never shown together
    a_r3_ready_fatal_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(ctrl_status[0] && ctrl_status[1]));

    // R3: ready only appears after a configuration write carrying the enable bit
    a_r3_ready_after_enable: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ctrl_status[0]) |-> $past(bus_valid && bus_write
            && bus_addr == ADDR_W'(8'h14) && bus_wdata[0]));

    // R5: a clear pulse follows a configuration write
    a_r5_clear_from_cfg_write: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_clear |-> $past(bus_valid && bus_write && bus_addr == ADDR_W'(8'h14)));

    // R8: status writes leave the status unchanged
    a_r8_stat_write_keeps_status: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_write && bus_addr == ADDR_W'(8'h1C)) |=> $stable(ctrl_status));

    // R11: misaligned accesses flag reason 1
    a_r11_misalign_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_addr[1:0] != 2'b00) |=> (ua_strobe && ua_code == 4'd1));

    // R10: every strobe carries a reason
    a_r10_strobe_has_code: assert property (@(posedge clk) disable iff (!rst_n)
        ua_strobe |-> (ua_code != 4'd0));
endmodule

bind sc_regbank sc_regbank_chk #(.ADDR_W(ADDR_W)) u_sc_regbank_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_valid   (bus_valid),
    .bus_write   (bus_write),
    .bus_addr    (bus_addr),
    .bus_wdata   (bus_wdata),
    .ctrl_clear  (ctrl_clear),
    .ctrl_status (ctrl_status),
    .ua_strobe   (ua_strobe),
    .ua_code     (ua_code)
);

// File: tb/sc_regbank_bench.sv
`timescale 1ns/100ps
module sc_regbank_bench;
    localparam int ADDR_W   = 12;
    localparam int WD_LIMIT = 20000;
    localparam int NVEC     = 14;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              bus_valid = 1'b0, bus_write = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [2:0]        bus_bytes = 3'd4;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic              msix_on = 1'b0, adm_sq_live = 1'b0, adm_cq_live = 1'b0;
    logic [3:0]        cap_pg_min = 4'd0, cap_pg_max = 4'd4;
    logic [3:0]        cap_cqe_min = 4'd4, cap_cqe_max = 4'd4;
    logic [3:0]        cap_sqe_min = 4'd6, cap_sqe_max = 4'd6;
    logic              ctrl_clear, ua_strobe;
    logic [3:0]        ctrl_status, start_fault, ua_code;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;

    sc_regbank #(.ADDR_W(ADDR_W)) u_sc_regbank (.*);

    // {write addr, write data, read addr, expected read, expected reason}
    localparam logic [91:0] VEC [NVEC] = '{
        {12'h00C, 32'h0000_00F0, 12'h010, 32'h0000_00F0, 4'd0},
        {12'h010, 32'h0000_0030, 12'h00C, 32'h0000_00C0, 4'd0},
        {12'h028, 32'h1234_5000, 12'h028, 32'h1234_5000, 4'd0},
        {12'h02C, 32'h0000_000A, 12'h02C, 32'h0000_000A, 4'd0},
        {12'h02C, 32'h0000_0005, 12'h02C, 32'h0000_000F, 4'd0},
        {12'h028, 32'h0000_2000, 12'h02C, 32'h0000_0000, 4'd0},
        {12'h01C, 32'h0000_0001, 12'h01C, 32'h0000_0000, 4'd5},
        {12'h01C, 32'h0000_0010, 12'h01C, 32'h0000_0000, 4'd4},
        {12'h038, 32'h0000_DEAD, 12'h038, 32'h0000_0000, 4'd7},
        {12'h03C, 32'h0000_0001, 12'h03C, 32'h0000_0000, 4'd7},
        {12'h024, 32'h001F_001F, 12'h024, 32'h001F_001F, 4'd0},
        {12'h020, 32'h4E56_4D65, 12'h024, 32'h001F_001F, 4'd6},
        {12'h020, 32'h0000_0001, 12'h020, 32'h0000_0000, 4'd0},
        {12'h000, 32'h0000_0005, 12'h000, 32'h0000_0000, 4'd8}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    task automatic acc(input logic w, input logic [ADDR_W-1:0] a,
                       input logic [31:0] d, input logic [2:0] by);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = w; bus_addr = a; bus_wdata = d; bus_bytes = by;
        @(posedge clk);
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0; bus_bytes = 3'd4;
    endtask

    task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
        acc(1'b1, a, d, 3'd4);
    endtask

    task automatic rd_check(input string tag, input logic [ADDR_W-1:0] a, input logic [31:0] exp);
        acc(1'b0, a, 32'h0, 3'd4);
        check(tag, bus_rdata, exp);
    endtask

    // enable attempt, then disable so the next attempt is a fresh rise
    task automatic try_en(input string tag, input logic [31:0] cfgw,
                          input logic [3:0] exp_fault, input logic [3:0] exp_stat);
        wr(12'h014, cfgw);
        check({tag, " start_fault"}, 32'(start_fault), 32'(exp_fault));
        check({tag, " status"}, 32'(ctrl_status), 32'(exp_stat));
        wr(12'h014, 32'h0);
        check({tag, " R5 clear pulse on enable fall"}, 32'(ctrl_clear), 32'd1);
    endtask

    initial begin
        #(WD_LIMIT * 5);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog all requirements actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R12 reset state
        check("R12 status after reset", 32'(ctrl_status), 32'h0);
        check("R12 start_fault after reset", 32'(start_fault), 32'h0);
        check("R12 no clear pulse", 32'(ctrl_clear), 32'h0);
        check("R12 no strobe", 32'(ua_strobe), 32'h0);
        rd_check("R12 config after reset", 12'h014, 32'h0);
        rd_check("R12 mask after reset", 12'h00C, 32'h0);

        // table: R1 R7 R8 R9 R10
        for (int i = 0; i < NVEC; i++) begin
            wr(VEC[i][91:80], VEC[i][79:48]);
            check($sformatf("R1/R7/R8/R9/R10 vec %0d reason", i), 32'(ua_code), 32'(VEC[i][3:0]));
            check($sformatf("R1/R7/R8/R9/R10 vec %0d strobe", i), 32'(ua_strobe),
                  32'(VEC[i][3:0] != 4'd0));
            rd_check($sformatf("R1/R7/R8/R9/R10 vec %0d readback", i), VEC[i][47:36], VEC[i][35:4]);
        end

        // R11 misaligned write ignored, misaligned read is zero
        wr(12'h00D, 32'hFF);
        check("R11 misaligned write reason", 32'(ua_code), 32'd1);
        rd_check("R11 misaligned write no effect", 12'h00C, 32'hC0);
        acc(1'b0, 12'h00E, 32'h0, 3'd4);
        check("R11 misaligned read zero", bus_rdata, 32'h0);
        check("R11 misaligned read reason", 32'(ua_code), 32'd1);
        // R11 narrow write takes effect
        acc(1'b1, 12'h00C, 32'h1, 3'd2);
        check("R11 narrow write reason", 32'(ua_code), 32'd2);
        rd_check("R11 narrow write effect", 12'h00C, 32'hC1);
        // R2 mask write with message interrupts on
        msix_on = 1'b1;
        wr(12'h010, 32'h1);
        check("R2 mask write reason", 32'(ua_code), 32'd3);
        msix_on = 1'b0;
        rd_check("R2 mask write took effect", 12'h00C, 32'hC0);
        // R10 read beyond window
        acc(1'b0, 12'h040, 32'h0, 3'd4);
        check("R10 read beyond window data", bus_rdata, 32'h0);
        check("R10 read beyond window reason", 32'(ua_code), 32'd9);
        wr(12'h040, 32'h1);
        check("R10 write beyond window reason", 32'(ua_code), 32'd8);

        // R3 R4 ordered start checks
        adm_sq_live = 1'b1; adm_cq_live = 1'b1;
        wr(12'h028, 32'h0); wr(12'h030, 32'h0); wr(12'h024, 32'h0);
        try_en("R4 cq live", 32'h0046_0001, 4'd1, 4'h2);
        check("R5 fatal kept after enable fall", 32'(ctrl_status), 32'h2);
        adm_cq_live = 1'b0;
        try_en("R4 sq live", 32'h0046_0001, 4'd2, 4'h2);
        adm_sq_live = 1'b0;
        try_en("R4 sq base zero", 32'h0046_0001, 4'd3, 4'h2);
        wr(12'h028, 32'h0000_0800);
        try_en("R4 cq base zero", 32'h0046_0001, 4'd4, 4'h2);
        wr(12'h030, 32'h0000_0801);
        try_en("R4 sq misaligned", 32'h0046_0001, 4'd5, 4'h2);
        wr(12'h028, 32'h0010_0000);
        try_en("R4 cq misaligned", 32'h0046_0001, 4'd6, 4'h2);
        wr(12'h030, 32'h0010_0000);
        cap_pg_min = 4'd1;
        try_en("R4 page too small", 32'h0046_0001, 4'd7, 4'h2);
        cap_pg_min = 4'd0;
        try_en("R4 page too large", 32'h0046_0281, 4'd8, 4'h2);
        try_en("R4 cq entry low", 32'h0036_0001, 4'd9, 4'h2);
        try_en("R4 cq entry high", 32'h0056_0001, 4'd10, 4'h2);
        try_en("R4 sq entry low", 32'h0045_0001, 4'd11, 4'h2);
        try_en("R4 sq entry high", 32'h0047_0001, 4'd12, 4'h2);
        wr(12'h024, 32'h0001_0000);
        try_en("R4 sq size zero", 32'h0046_0001, 4'd13, 4'h2);
        wr(12'h024, 32'h0000_0001);
        try_en("R4 cq size zero", 32'h0046_0001, 4'd14, 4'h2);
        wr(12'h024, 32'h0001_0001);
        wr(12'h014, 32'h0046_0001);
        check("R3 pass fault code", 32'(start_fault), 32'd0);
        check("R3 pass status ready", 32'(ctrl_status), 32'h1);
        check("R3 no clear on enable rise", 32'(ctrl_clear), 32'd0);

        // R13 dropped configuration write
        wr(12'h014, 32'h0046_0081);
        rd_check("R13 config unchanged", 12'h014, 32'h0046_0001);
        check("R13 status unchanged", 32'(ctrl_status), 32'h1);

        // R6 shutdown
        wr(12'h014, 32'h0046_4001);
        check("R6 clear on shutdown set", 32'(ctrl_clear), 32'd1);
        check("R6 shutdown complete", 32'(ctrl_status), 32'h9);
        wr(12'h014, 32'h0046_0001);
        check("R6 no clear on shutdown release", 32'(ctrl_clear), 32'd0);
        check("R6 shutdown state cleared", 32'(ctrl_status), 32'h1);

        // R5 enable fall from ready
        wr(12'h014, 32'h0);
        check("R5 clear on enable fall", 32'(ctrl_clear), 32'd1);
        check("R5 ready cleared", 32'(ctrl_status), 32'h0);
        rd_check("R5 config stored on fall", 12'h014, 32'h0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule